// File: doc/BRIEF.md
# Modular Exponentiation Engine (square-and-multiply)

This block raises a base to a power modulo an odd modulus, with all three operands W bits wide (W is 16 by default). The exponent is treated as a chain of one-bit stages. Each stage holds a base term that is the square of the term before it, and the first term is the base itself. A stage whose exponent bit is set multiplies its term into a running accumulator. A stage whose bit is clear leaves the accumulator unchanged, which is the same as multiplying by one. The number of stages equals the exponent width.

All arithmetic runs on one sequential multiply-and-reduce datapath. A full 2W-bit product is formed in a single cycle. A restoring shift-and-subtract loop then reduces it one product bit per cycle, so every held value stays in the range 0 to n-1.

A caller presents the operands with a one-cycle start pulse. It then waits for the one-cycle done pulse and reads the result, which stays on the output until the next job finishes.

Top module: `modexp_sqmul`

## Requirements
- R1: For any nonzero modulus n, the result equals a^x mod n. The exponent bits are used from bit 0 upward, one stage per bit, for W stages.
- R2: An exponent of zero gives 1 mod n. This is 1 for n greater than 1 and 0 for n equal to 1. A modulus of 1 gives 0 for every base and exponent.
- R3: A base of 0 with a nonzero exponent gives 0. A base of 1 gives 1 mod n for every exponent.
- R4: A base greater than or equal to n is reduced modulo n before the first stage, so the result is still a^x mod n.
- R5: While reset is held, and right after it, busy is 0, done is 0 and result is 0.
- R6: A start pulse seen while busy is 0 is accepted, and busy is 1 in the next cycle. done is high for exactly one cycle, and busy is 0 in that same cycle.
- R7: done rises exactly (2W+1)·(1+k) + W·(2W+2) + 1 clock edges after the edge that accepted start, where k is the number of set bits in the exponent.
- R8: A start pulse seen while busy is 1 is ignored. The running job keeps its operands, its result and its completion cycle.
- R9: result changes only on the edge that raises done. Between two done pulses it holds its value, including while a later job is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request that begins a job with the current operands |
| base_i | input | W | Base a |
| exp_i | input | W | Exponent x |
| mod_i | input | W | Modulus n: nonzero, odd in normal use |
| busy | output | 1 | High while a job is in progress |
| done | output | 1 | One-cycle pulse when result is updated |
| result | output | W | a^x mod n from the last finished job |

## Verification
The only result is due on the edge that raises done. That edge comes a fixed number of edges after the accepting edge, and the number depends only on W and the count of set exponent bits (R7). The bench drives inputs on falling edges and counts rising edges from the accepting edge until done is seen. It checks that count against the formula, compares the result with a software modular power, and samples once more one cycle later to confirm that done has dropped. busy is checked one edge after start. Holding and ignore behaviour is checked by sampling result at falling edges across idle stretches, and across a job that receives a second, conflicting start pulse.

// File: rtl/modexp_sqmul.sv
module modexp_sqmul #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] exp_i,
  input  logic [W-1:0] mod_i,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int PW = 2 * W;
  localparam int CW = $clog2(PW + 1);
  localparam int BW = $clog2(W + 1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_STEP, S_MUL, S_SQR} st_t;

  st_t           st;
  logic [W-1:0]  nmod, acc, sqv, ebits;
  logic [BW-1:0] bitcnt;
  logic [PW-1:0] prod;
  logic [W:0]    rem;
  logic [CW-1:0] rcnt;

  logic [W:0] trial, rem_nxt;
  logic       red_last;

  assign busy     = (st != S_IDLE);
  assign trial    = {rem[W-1:0], prod[PW-1]};
  assign rem_nxt  = (trial >= {1'b0, nmod}) ? trial - {1'b0, nmod} : trial;
  assign red_last = (rcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      nmod   <= '0;
      acc    <= '0;
      sqv    <= '0;
      ebits  <= '0;
      bitcnt <= '0;
      prod   <= '0;
      rem    <= '0;
      rcnt   <= '0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          nmod   <= mod_i;
          ebits  <= exp_i;
          acc    <= {{(W-1){1'b0}}, (mod_i != W'(1))};
          prod   <= {{W{1'b0}}, base_i};
          rem    <= '0;
          rcnt   <= CW'(PW);
          bitcnt <= BW'(W);
          st     <= S_LOAD;
        end
        S_STEP: begin
          if (bitcnt == '0) begin
            result <= acc;
            done   <= 1'b1;
            st     <= S_IDLE;
          end else begin
            rem  <= '0;
            rcnt <= CW'(PW);
            if (ebits[0]) begin
              prod <= PW'(acc) * PW'(sqv);
              st   <= S_MUL;
            end else begin
              prod <= PW'(sqv) * PW'(sqv);
              st   <= S_SQR;
            end
          end
        end
        default: begin
          if (!red_last) begin
            rem  <= rem_nxt;
            prod <= prod << 1;
            rcnt <= rcnt - CW'(1);
          end else if (st == S_LOAD) begin
            sqv <= rem[W-1:0];
            st  <= S_STEP;
          end else if (st == S_MUL) begin
            acc  <= rem[W-1:0];
            prod <= PW'(sqv) * PW'(sqv);
            rem  <= '0;
            rcnt <= CW'(PW);
            st   <= S_SQR;
          end else begin
            sqv    <= rem[W-1:0];
            ebits  <= ebits >> 1;
            bitcnt <= bitcnt - BW'(1);
            st     <= S_STEP;
          end
        end
      endcase
    end
  end

  p_rem_below_mod_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st != S_STEP) |-> (rem < {1'b0, nmod}));

  p_result_below_mod_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result < nmod));

  p_accept_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(nmod));

  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (done || $stable(result)));
endmodule

// File: tb/tb_modexp_sqmul.sv
module tb_modexp_sqmul;
  localparam int W = 16;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] base_i = '0;
  logic [W-1:0] exp_i = '0;
  logic [W-1:0] mod_i = 16'd1;
  logic         busy, done;
  logic [W-1:0] result;

  int checks = 0;
  int fails  = 0;

  modexp_sqmul #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_i(base_i),
    .exp_i(exp_i), .mod_i(mod_i), .busy(busy), .done(done), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint unsigned modpow(input longint unsigned a, x, n);
    longint unsigned r = 1 % n;
    longint unsigned b = a % n;
    for (int i = 0; i < W; i++) begin
      if (x[i]) r = (r * b) % n;
      b = (b * b) % n;
    end
    return r;
  endfunction

  function automatic int latency(input logic [W-1:0] x);
    int r = 2 * W + 1;
    return r * (1 + $countones(x)) + W * (2 * W + 2) + 1;
  endfunction

  task automatic run_op(input logic [W-1:0] a, x, n, input string req, input bit intrude);
    longint unsigned want = modpow(a, x, n);
    int lat = latency(x);
    int c = 0;
    @(negedge clk);
    base_i = a; exp_i = x; mod_i = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R6", busy, 1);
    while (!done && c < 20000) begin
      @(negedge clk);
      c++;
      if (intrude && c == 10) begin
        start = 1'b1; base_i = ~a; exp_i = ~x; mod_i = n ^ 16'h0002;
      end else begin
        start = 1'b0;
      end
    end
    chk(result == want[W-1:0], req, result, want);
    chk(c == lat, "R7", c, lat);
    @(negedge clk);
    chk(done == 1'b0, "R6", done, 0);
  endtask

  task automatic t_reset;
    chk(busy == 1'b0 && done == 1'b0 && result == '0, "R5", {busy, done, result}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && result == '0, "R5", {busy, done, result}, 0);
  endtask

  task automatic t_random;
    for (int i = 0; i < 12; i++) begin
      logic [W-1:0] n = W'($urandom) | 16'd1;
      logic [W-1:0] a = W'($urandom) % n;
      run_op(a, W'($urandom), n, "R1", 1'b0);
    end
    run_op(16'd3, 16'hFFFF, 16'hFFF1, "R1", 1'b0);
    run_op(16'd7, 16'd13, 16'd101, "R1", 1'b0);
  endtask

  task automatic t_edges;
    run_op(16'd1234, 16'd0, 16'd997, "R2", 1'b0);
    run_op(16'd1234, 16'd0, 16'd1, "R2", 1'b0);
    run_op(16'd4321, 16'hBEEF, 16'd1, "R2", 1'b0);
    run_op(16'd0, 16'd5, 16'd997, "R3", 1'b0);
    run_op(16'd1, 16'hFFFF, 16'd4093, "R3", 1'b0);
    run_op(16'd1, 16'd77, 16'd1, "R3", 1'b0);
  endtask

  task automatic t_big_base;
    run_op(16'hFFFF, 16'd11, 16'd251, "R4", 1'b0);
    run_op(16'd1000, 16'hA5A5, 16'd999, "R4", 1'b0);
  endtask

  task automatic t_busy_start;
    run_op(16'd17, 16'h1357, 16'd30011, "R8", 1'b1);
  endtask

  task automatic t_hold;
    logic [W-1:0] keep;
    run_op(16'd5, 16'd3, 16'd13, "R9", 1'b0);
    keep = result;
    repeat (20) @(negedge clk);
    chk(result == keep, "R9", result, keep);
    @(negedge clk);
    base_i = 16'd2; exp_i = 16'd10; mod_i = 16'd1001; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (100) @(negedge clk);
    chk(result == keep && busy, "R9", result, keep);
    while (!done) @(negedge clk);
    chk(result == W'(1024 % 1001), "R9", result, 1024 % 1001);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    t_reset();
    t_random();
    t_edges();
    t_big_base();
    t_busy_start();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule